// File: doc/BRIEF.md
# Watchdog and Sleep Controller

This block supervises a small microcontroller core. A free-running tick feeds a power-of-two prescaler, whose output advances an 8-bit watchdog counter. If software fails to restart the counter chain before the counter wraps, the block takes action. While the core is running, it raises a one-cycle reset request. While the core is powered down, it raises a one-cycle wake request and lets the oscillator run again.

The instruction decoder drives two command strobes into the block, one for a watchdog restart and one for power-down. Each command clears the prescaler and the counter. Each command also loads the time-out and power-down status bits with its own fixed pattern. After a reset or a wake-up, software reads these two bits to learn why it is running.

While the core sleeps, the block holds an oscillator-stop enable high. No instruction can execute during sleep, so the block ignores both command strobes until the watchdog wakes the core.

Top module: `wdt_sleep_ctrl`

## Requirements
- R1: After the synchronous reset, status_to_o = 1, status_pd_o = 1, and wdt_reset_o, wake_o and osc_stop_o are all 0. The prescaler and the counter start at zero, so the first overflow comes on the 256·2^sel-th tick.
- R2: A cycle counts only when tick_i is high. presc_sel_i = s (0..7) divides the tick count by 2^s. The watchdog therefore overflows on exactly the 256·2^s-th counted tick after the chain was last cleared.
- R3: An overflow while awake drives wdt_reset_o high for exactly one cycle, in the cycle after the overflowing tick. In the same update it clears status_to_o and leaves status_pd_o unchanged.
- R4: After an overflow, the chain continues from zero with no command. The next overflow comes one full period later.
- R5: A restart command (clrwdt_i while awake) clears the chain and sets status_to_o = 1 and status_pd_o = 1 from the next cycle. A tick in the same cycle is not counted.
- R6: A power-down command (sleep_i while awake) clears the chain. From the next cycle it sets status_to_o = 1, status_pd_o = 0 and osc_stop_o = 1.
- R7: An overflow while asleep pulses wake_o for one cycle, drops osc_stop_o and clears status_to_o, all in the same cycle. status_pd_o stays 0 and wdt_reset_o stays 0.
- R8: While osc_stop_o = 1, clrwdt_i and sleep_i have no effect. The status bits and the overflow time are unchanged.
- R9: When clrwdt_i and sleep_i arrive together while awake, the power-down command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Watchdog time-base strobe, one cycle per tick |
| presc_sel_i | input | 3 | Prescaler divide exponent (divide by 2^value) |
| clrwdt_i | input | 1 | Watchdog restart command strobe |
| sleep_i | input | 1 | Power-down command strobe |
| status_to_o | output | 1 | Time-out status bit (0 after a watchdog overflow) |
| status_pd_o | output | 1 | Power-down status bit (0 after a power-down command) |
| wdt_reset_o | output | 1 | One-cycle reset request on overflow while awake |
| wake_o | output | 1 | One-cycle wake request on overflow while asleep |
| osc_stop_o | output | 1 | Oscillator-stop enable, high while asleep |

## Verification
A prescaler or counter holding a wrong value shows up only as an overflow pulse at the wrong tick. The bench therefore counts ticks from each clear for every divide setting and requires the pulse on exactly the 256·2^s-th tick, with none before it. In this way an off-by-one in either stage is caught within one period. A wrong power state or status register shows up in the cycle after the command or the overflow: it can steer the wrong pulse output, leave osc_stop_o in the wrong level, or give the wrong status_to_o and status_pd_o pattern. The bench samples all of these one cycle after each event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        PWR_AWAKE  = 1'b0,
        PWR_ASLEEP = 1'b1
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_SLEEP = 2'd2
    } wdt_cmd_e;

    typedef struct packed {
        logic to;
        logic pd;
    } wdt_status_t;

    typedef struct packed {
        logic rst_req;
        logic wake;
    } wdt_event_t;

    localparam wdt_status_t ST_POWER_ON = '{to: 1'b1, pd: 1'b1};
    localparam wdt_status_t ST_CLEARED  = '{to: 1'b1, pd: 1'b1};
    localparam wdt_status_t ST_SLEEPING = '{to: 1'b1, pd: 1'b0};
    localparam wdt_event_t  EV_NONE     = '{rst_req: 1'b0, wake: 1'b0};

    // Power-down wins over restart when both strobes arrive together.
    function automatic wdt_cmd_e decode_cmd(input logic clr, input logic slp);
        if (slp)      return CMD_SLEEP;
        else if (clr) return CMD_CLEAR;
        else          return CMD_NONE;
    endfunction

    // A time-out clears the time-out bit and keeps the power-down bit.
    function automatic wdt_status_t after_timeout(input wdt_status_t s);
        wdt_status_t r;
        r    = s;
        r.to = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SEL_W = 3,
    localparam int PRE_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             strobe_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    // Bit i takes part in the divide when the exponent is above i.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(sel_i) > i);
    end

    assign strobe_o = tick_i && !clr_i && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

    // R5
    presc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!strobe_o || sel_i == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic step_i,
    output logic ovf_o
);
    logic [CNT_W-1:0] cnt_q;

    assign ovf_o = step_i && !clr_i && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_power_ctl.sv
module wdt_power_ctl
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clrwdt_i,
    input  logic        sleep_i,
    input  logic        ovf_i,
    output logic        chain_clr_o,
    output wdt_status_t status_o,
    output wdt_event_t  event_o,
    output logic        asleep_o
);
    pwr_state_e  state_q, state_d;
    wdt_status_t status_q, status_d;
    wdt_event_t  event_q, event_d;
    wdt_cmd_e    cmd;

    always_comb begin
        cmd = (state_q == PWR_ASLEEP) ? CMD_NONE : decode_cmd(clrwdt_i, sleep_i);
    end

    assign chain_clr_o = (cmd != CMD_NONE);

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        event_d  = EV_NONE;
        case (cmd)
            CMD_SLEEP: begin
                status_d = ST_SLEEPING;
                state_d  = PWR_ASLEEP;
            end
            CMD_CLEAR: begin
                status_d = ST_CLEARED;
            end
            default: begin
                if (ovf_i) begin
                    status_d = after_timeout(status_q);
                    if (state_q == PWR_ASLEEP) begin
                        event_d.wake = 1'b1;
                        state_d      = PWR_AWAKE;
                    end else begin
                        event_d.rst_req = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PWR_AWAKE;
            status_q <= ST_POWER_ON;
            event_q  <= EV_NONE;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            event_q  <= event_d;
        end
    end

    assign status_o = status_q;
    assign event_o  = event_q;
    assign asleep_o = (state_q == PWR_ASLEEP);

    // R3
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        event_q.rst_req |=> !event_q.rst_req);

    // R3
    rst_clears_to_chk: assert property (@(posedge clk) disable iff (rst)
        event_q.rst_req |-> !status_q.to);

    // R7
    wake_releases_osc_chk: assert property (@(posedge clk) disable iff (rst)
        event_q.wake |-> ($past(state_q) == PWR_ASLEEP) && (state_q == PWR_AWAKE) && !status_q.to);

    // R6
    sleep_pd_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_ASLEEP) |-> !status_q.pd);

    // R7
    no_dual_event_chk: assert property (@(posedge clk) disable iff (rst)
        !(event_q.wake && event_q.rst_req));

    // R8
    asleep_pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PWR_ASLEEP) && $past(state_q) == PWR_ASLEEP) |-> $stable(status_q.pd));

endmodule

// File: rtl/wdt_sleep_ctrl.sv
module wdt_sleep_ctrl
    import wdt_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] presc_sel_i,
    input  logic             clrwdt_i,
    input  logic             sleep_i,
    output logic             status_to_o,
    output logic             status_pd_o,
    output logic             wdt_reset_o,
    output logic             wake_o,
    output logic             osc_stop_o
);
    logic        chain_clr;
    logic        presc_strobe;
    logic        cnt_ovf;
    wdt_status_t status;
    wdt_event_t  events;
    logic        asleep;

    wdt_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (chain_clr),
        .tick_i   (tick_i),
        .sel_i    (presc_sel_i),
        .strobe_o (presc_strobe)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (chain_clr),
        .step_i (presc_strobe),
        .ovf_o  (cnt_ovf)
    );

    wdt_power_ctl u_pwr (
        .clk         (clk),
        .rst         (rst),
        .clrwdt_i    (clrwdt_i),
        .sleep_i     (sleep_i),
        .ovf_i       (cnt_ovf),
        .chain_clr_o (chain_clr),
        .status_o    (status),
        .event_o     (events),
        .asleep_o    (asleep)
    );

    assign status_to_o = status.to;
    assign status_pd_o = status.pd;
    assign wdt_reset_o = events.rst_req;
    assign wake_o      = events.wake;
    assign osc_stop_o  = asleep;

    // R9
    dual_cmd_sleeps_chk: assert property (@(posedge clk) disable iff (rst)
        (clrwdt_i && sleep_i && !osc_stop_o) |=> (osc_stop_o && !status_pd_o));

endmodule

// File: tb/wdt_sleep_ctrl_tb.sv
module wdt_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [2:0] presc_sel_i = 3'd0;
    logic       clrwdt_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       status_to_o, status_pd_o, wdt_reset_o, wake_o, osc_stop_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wdt_sleep_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .presc_sel_i (presc_sel_i),
        .clrwdt_i    (clrwdt_i),
        .sleep_i     (sleep_i),
        .status_to_o (status_to_o),
        .status_pd_o (status_pd_o),
        .wdt_reset_o (wdt_reset_o),
        .wake_o      (wake_o),
        .osc_stop_o  (osc_stop_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample just after the rising edge.
    task automatic step(input logic t, input logic c, input logic s);
        @(negedge clk);
        tick_i   = t;
        clrwdt_i = c;
        sleep_i  = s;
        @(posedge clk);
        #1;
    endtask

    // Apply n ticks (gap idle cycles before each) and check the event on the last.
    task automatic run_period(input string tag, input int n, input int gap, input bit asleep);
        int early = 0;
        for (int i = 0; i < n - 1; i++) begin
            for (int g = 0; g < gap; g++) begin
                step(1'b0, 1'b0, 1'b0);
                if (wdt_reset_o || wake_o) early++;
            end
            step(1'b1, 1'b0, 1'b0);
            if (wdt_reset_o || wake_o) early++;
        end
        chk({tag, " no early event"}, early, 0);
        step(1'b1, 1'b0, 1'b0);
        chk({tag, " reset pulse"}, int'(wdt_reset_o), asleep ? 0 : 1);
        chk({tag, " wake pulse"}, int'(wake_o), asleep ? 1 : 0);
        chk({tag, " TO cleared"}, int'(status_to_o), 0);
        chk({tag, " osc released"}, int'(osc_stop_o), 0);
        step(1'b0, 1'b0, 1'b0);
        chk({tag, " pulse one cycle"}, int'(wdt_reset_o | wake_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 TO", int'(status_to_o), 1);
        chk("R1 PD", int'(status_pd_o), 1);
        chk("R1 pulses", int'(wdt_reset_o | wake_o), 0);
        chk("R1 osc", int'(osc_stop_o), 0);
        // R1 first period from reset, no clear
        run_period("R1 from reset", 256, 0, 1'b0);
        chk("R3 PD unchanged", int'(status_pd_o), 1);
        // R4 continues without a command
        run_period("R4 free run", 256, 0, 1'b0);

        // R2 sweep over all divide settings
        for (int s = 0; s < 8; s++) begin
            presc_sel_i = 3'(s);
            step(1'b0, 1'b1, 1'b0);
            chk("R5 TO set", int'(status_to_o), 1);
            chk("R5 PD set", int'(status_pd_o), 1);
            run_period("R2 sweep", 256 << s, 0, 1'b0);
        end
        // R2 idle cycles between ticks do not count
        for (int s = 0; s < 3; s++) begin
            presc_sel_i = 3'(s);
            step(1'b0, 1'b1, 1'b0);
            run_period("R2 sparse", 256 << s, 2, 1'b0);
        end

        // R5 restart mid-count with a tick in the same cycle
        presc_sel_i = 3'd2;
        step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 700; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        run_period("R5 restart", 1024, 0, 1'b0);

        // R6 / R7 power-down then watchdog wake
        for (int s = 0; s < 2; s++) begin
            presc_sel_i = 3'(s);
            step(1'b0, 1'b1, 1'b0);
            for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b1);
            chk("R6 TO", int'(status_to_o), 1);
            chk("R6 PD", int'(status_pd_o), 0);
            chk("R6 osc stop", int'(osc_stop_o), 1);
            run_period("R7 wake", 256 << s, 0, 1'b1);
            chk("R7 PD stays low", int'(status_pd_o), 0);
            step(1'b0, 1'b1, 1'b0);
            chk("R5 PD after wake restart", int'(status_pd_o), 1);
        end

        // R8 commands ignored while asleep
        presc_sel_i = 3'd0;
        step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 128; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R8 PD after clear asleep", int'(status_pd_o), 0);
        chk("R8 osc after clear asleep", int'(osc_stop_o), 1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R8 still asleep", int'(osc_stop_o), 1);
        run_period("R8 wake time kept", 128, 0, 1'b1);

        // R9 both strobes together
        step(1'b0, 1'b1, 1'b1);
        chk("R9 PD", int'(status_pd_o), 0);
        chk("R9 TO", int'(status_to_o), 1);
        chk("R9 osc stop", int'(osc_stop_o), 1);
        run_period("R9 wake", 256, 0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule